// File: doc/BRIEF.md
# Fan tachometer pulse-width meter

This block measures how long a fan tachometer line stays high and reports that time as an 8-bit code. Software reads the code and converts it to RPM. The tachometer pin is asynchronous to the block. It first passes through a synchroniser. It is then sampled once per sample period, and the period is a programmable multiple of a base cycle count. Each sample taken while the line stays high adds one to a count. When the high period ends, the block subtracts a configurable minimum-samples offset from the count, clamps the result and holds it on the output.

Code 0x00 is the fastest speed the block can measure. Code 0xFE is the slowest, and any longer high time also reports 0xFE. Code 0xFF never comes from a measurement. It is reserved for a stalled or absent fan: the line has shown no level change for 256 consecutive samples. The fault clears by itself once a complete pulse has been measured.

Top module: `tach_width_meter`

## Requirements
- R1: After reset, and after any later reset, `code_o` is 0x00 and `fault_o` is 0.
- R2: `tach_i` passes through a two-flop synchroniser and is sampled once every P clocks, where P = M × `BASE_CYCLES` and M is the effective multiplier. A high level held for H×P clocks counts as H samples.
- R3: The effective multiplier M equals `div_mult_i` when that input is between 1 and 64. A value of 0, or any value above 64, selects M = 4.
- R4: When a high period of H samples ends and K = `min_samples_i` satisfies K ≤ H < K+254, `code_o` becomes H−K.
- R5: When H ≥ K+254, `code_o` becomes 0xFE. A measurement never produces 0xFF.
- R6: When H < K, `code_o` becomes 0x00.
- R7: After 256 consecutive samples with no change in the sampled level, `fault_o` is 1 and `code_o` reads 0xFF.
- R8: A sampled falling edge that ends a high period clears `fault_o`. A rising edge alone leaves the fault set.
- R9: The measured code changes only on the sampled falling edge that ends a high period. While a later high period is still in progress, the previous code is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tach_i | input | 1 | Tachometer line, asynchronous to the clock |
| div_mult_i | input | MULT_W | Sample-period multiplier (1..64; 0 or above 64 selects 4) |
| min_samples_i | input | 8 | Minimum-samples offset K |
| code_o | output | 8 | Measured code, or 0xFF while faulted |
| fault_o | output | 1 | Tachometer fault flag |

## Verification
The assertions treat `tach_i` as fully arbitrary. They rely only on the sample tick and the sampled level being the sole inputs to the code and fault state. The tick-spacing property also assumes that the multiplier does not change between two consecutive ticks. The bench changes the multiplier and the offset only while the line is low, then waits two sample periods before the next pulse. It holds every level for a whole multiple of the sample period, so the sample count it expects does not depend on where the tick falls relative to the edges.

// File: rtl/tach_meter_pkg.sv
`timescale 1ns/1ps
package tach_meter_pkg;
  localparam int unsigned CODE_W   = 8;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t       CODE_FAULT = 8'hFF;
  localparam code_t       CODE_SLOW  = 8'hFE;
  localparam int unsigned MULT_MAX   = 64;
  localparam int unsigned MULT_DEF   = 4;
endpackage

// File: rtl/tach_sync.sv
`timescale 1ns/1ps
module tach_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/tach_tick_gen.sv
`timescale 1ns/1ps
module tach_tick_gen
  import tach_meter_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 283,
  parameter int unsigned MULT_W      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MULT_W-1:0] mult_i,
  output logic              tick_o
);
  localparam int unsigned PER_MAX = BASE_CYCLES * MULT_MAX;
  localparam int unsigned PER_W   = $clog2(PER_MAX + 1);

  logic [MULT_W-1:0] eff_mult;
  logic [PER_W-1:0]  period;
  logic [PER_W-1:0]  cnt_q;

  // out-of-range multiplier falls back to the default
  always_comb begin
    if (mult_i == '0 || mult_i > MULT_W'(MULT_MAX)) eff_mult = MULT_W'(MULT_DEF);
    else                                             eff_mult = mult_i;
  end

  assign period = PER_W'(eff_mult) * PER_W'(BASE_CYCLES);
  assign tick_o = (cnt_q >= period - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PER_W'(1);
  end

  // R2: with a stable multiplier, ticks are spaced by the period
  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_o) && $stable(mult_i) && period > PER_W'(1)) |-> !tick_o);
endmodule

// File: rtl/tach_width_core.sv
`timescale 1ns/1ps
module tach_width_core
  import tach_meter_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned IDLE_TICKS = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        lvl_i,
  input  logic [7:0]  min_i,
  output code_t       code_o,
  output logic        fault_o
);
  localparam int unsigned IDLE_W = $clog2(IDLE_TICKS);

  logic              lvl_q;
  logic [CNT_W-1:0]  n_q;
  logic [IDLE_W-1:0] idle_q;
  code_t             meas_q;
  logic              fault_q;
  logic              rise, fall, edge_s;
  logic [CNT_W-1:0]  k_ext, diff;
  code_t             clamped;

  assign rise   = tick_i &  lvl_i & ~lvl_q;
  assign fall   = tick_i & ~lvl_i &  lvl_q;
  assign edge_s = rise | fall;

  assign k_ext = {{(CNT_W-8){1'b0}}, min_i};
  assign diff  = n_q - k_ext;

  always_comb begin
    if (n_q < k_ext)                    clamped = '0;
    else if (diff >= CNT_W'(CODE_SLOW)) clamped = CODE_SLOW;
    else                                clamped = diff[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      n_q     <= '0;
      idle_q  <= '0;
      meas_q  <= '0;
      fault_q <= 1'b0;
    end else if (tick_i) begin
      lvl_q <= lvl_i;
      if (rise)                                n_q <= CNT_W'(1);
      else if (lvl_i && lvl_q && (n_q != '1))  n_q <= n_q + CNT_W'(1);
      if (fall) begin
        meas_q  <= clamped;
        fault_q <= 1'b0;
      end
      if (edge_s)                                  idle_q  <= '0;
      else if (idle_q == IDLE_W'(IDLE_TICKS - 1))  fault_q <= 1'b1;
      else                                         idle_q  <= idle_q + IDLE_W'(1);
    end
  end

  assign code_o  = fault_q ? CODE_FAULT : meas_q;
  assign fault_o = fault_q;

  assert_code_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_q <= CODE_SLOW);
  assert_update_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(meas_q) |-> $past(fall));
  assert_fault_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(tick_i && !edge_s));
  assert_fault_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_q) |-> $past(fall));
endmodule

// File: rtl/tach_width_meter.sv
`timescale 1ns/1ps
module tach_width_meter
  import tach_meter_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 283,
  parameter int unsigned MULT_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned IDLE_TICKS  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tach_i,
  input  logic [MULT_W-1:0] div_mult_i,
  input  logic [7:0]        min_samples_i,
  output logic [7:0]        code_o,
  output logic              fault_o
);
  logic tach_s;
  logic tick;

  tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tach_i), .q_o(tach_s)
  );

  tach_tick_gen #(.BASE_CYCLES(BASE_CYCLES), .MULT_W(MULT_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .mult_i(div_mult_i), .tick_o(tick)
  );

  tach_width_core #(.CNT_W(CNT_W), .IDLE_TICKS(IDLE_TICKS)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .lvl_i(tach_s),
    .min_i(min_samples_i), .code_o(code_o), .fault_o(fault_o)
  );
endmodule

// File: tb/tach_width_meter_bench.sv
`timescale 1ns/1ps
module tach_width_meter_bench;
  localparam int BASE = 4;
  localparam int NV   = 12;
  // {multiplier, K, high samples}
  localparam int VEC [0:NV-1][0:2] = '{
    '{1, 44, 50}, '{1, 44, 44}, '{1, 44, 30}, '{1, 44, 298},
    '{1, 44, 297}, '{1, 44, 400}, '{1, 10, 20}, '{3, 44, 60},
    '{0, 44, 60}, '{65, 44, 47}, '{1, 0, 5}, '{1, 44, 1}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tach_i = 1'b0;
  logic [6:0] div_mult_i = 7'd1;
  logic [7:0] min_samples_i = 8'd0;
  logic [7:0] code_o;
  logic       fault_o;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tach_width_meter #(.BASE_CYCLES(BASE)) u_tach_width_meter (
    .clk_i(clk), .rst_ni(rst_ni), .tach_i(tach_i), .div_mult_i(div_mult_i),
    .min_samples_i(min_samples_i), .code_o(code_o), .fault_o(fault_o)
  );

  function automatic int period_of(int m);
    return ((m < 1 || m > 64) ? 4 : m) * BASE;
  endfunction

  function automatic int expect_code(int h, int k);
    if (h < k) return 0;
    if (h - k >= 254) return 254;
    return h - k;
  endfunction

  task automatic check(input string tag, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp_v);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p;
    int last;
    wait_clks(3);
    rst_ni = 1'b1;
    wait_clks(1);
    check("R1 reset code", code_o, 0);
    check("R1 reset fault", fault_o, 0);

    // idle line -> fault after 256 samples (P = 4)
    wait_clks(250 * 4);
    check("R7 no fault before 256 samples", fault_o, 0);
    wait_clks(12 * 4);
    check("R7 fault flag", fault_o, 1);
    check("R7 fault code", code_o, 255);

    // rising edge alone keeps the fault; falling edge clears it
    min_samples_i = 8'd0;
    tach_i = 1'b1;
    wait_clks(5 * 4);
    check("R8 fault held on rise", fault_o, 1);
    tach_i = 1'b0;
    wait_clks(3 * 4);
    check("R8 fault cleared on fall", fault_o, 0);
    check("R4 code after fault pulse", code_o, 5);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      div_mult_i    = 7'(VEC[i][0]);
      min_samples_i = 8'(VEC[i][1]);
      p = period_of(VEC[i][0]);
      wait_clks(2 * p);
      tach_i = 1'b1;
      wait_clks(VEC[i][2] * p);
      tach_i = 1'b0;
      wait_clks(3 * p);
      check($sformatf("R4/R5/R6/R3 vec%0d code", i), code_o,
            expect_code(VEC[i][2], VEC[i][1]));
      check($sformatf("R2 vec%0d no fault", i), fault_o, 0);
    end

    // code held during a later high period
    last = expect_code(VEC[NV-1][2], VEC[NV-1][1]);
    div_mult_i = 7'd1;
    min_samples_i = 8'd44;
    wait_clks(2 * 4);
    tach_i = 1'b1;
    wait_clks(50 * 4);
    check("R9 code held mid-pulse", code_o, last);
    wait_clks(50 * 4);
    tach_i = 1'b0;
    wait_clks(3 * 4);
    check("R9 code updated on fall", code_o, 56);

    // asynchronous reset mid-run
    rst_ni = 1'b0;
    wait_clks(2);
    check("R1 reset again code", code_o, 0);
    check("R1 reset again fault", fault_o, 0);
    rst_ni = 1'b1;
    wait_clks(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule